// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns a single transfer request from a 16-bit processor core into the clock-by-clock phases of a bus on which address and data share the same lines. An accepted request starts an address phase, in which the address is driven and a one-clock latch-enable pulse is raised so that external latches can hold the address. A turnaround phase follows. For a read, the sequencer releases the shared lines; for a write, it puts the write data on them. A data phase follows, which the addressed device can stretch with whole-clock wait states by holding its ready line low. The cycle then closes with a final phase that reports completion.

Between requests the bus sits idle with every strobe inactive. A request presented during the final phase of a cycle starts the next address phase on the following clock, so cycles can run back to back with no idle clock between them. The shared lines are modelled as separate output, output-enable and input vectors so that a pad ring can form the tri-state buffer.

Top module: `mux_bus_seq`

## Requirements
- R1: Out of reset and on every idle clock: `ale`=0, `ad_oe`=0, `rd_n`=1, `wr_n`=1, `den`=0, `done`=0, `req_ready`=1, `dir_tx`=1, `bhe_n`=1.
- R2: A request taken on a clock edge (`req_valid` and `req_ready` both high) makes the next clock the address phase. In that phase `ale`=1, `ad_oe`=1, `ad_o` equals the request address, `bhe_n` equals the inverse of `req_hi`, and `dir_tx` equals `req_write`. `ale` is high for exactly that one clock.
- R3: For a read, `ad_oe` is 0 from the turnaround phase through the final phase. `rd_n` is 0 in the turnaround phase, the data phase and every wait state, and is 1 in the final phase. `wr_n` stays 1.
- R4: For a write, from the turnaround phase through the final phase `ad_oe`=1 and `ad_o` holds the write data zero-extended to the address width. `wr_n` is 0 in the turnaround phase, the data phase and every wait state, and is 1 in the final phase. `rd_n` stays 1.
- R5: `bus_ready` is sampled at the end of the data phase and at the end of each wait state. Each sample that is low adds exactly one wait-state clock, so a cycle with n low samples takes 4+n clocks from the address phase to the final phase inclusive.
- R6: `done` is high for exactly one clock, during the final phase.
- R7: For reads, `rd_data` takes `bus_ad_i` as sampled at the clock edge where `bus_ready` is first seen high, and holds that value until the next read capture.
- R8: `req_ready` is high only when idle or in the final phase. A request presented in the final phase makes the next clock an address phase, with no idle clock between the two cycles.
- R9: A request presented while a cycle is in progress has no effect on that cycle's address, data, direction or strobes.
- R10: `den` is 1 in the turnaround phase, the data phase, every wait state and the final phase, and is 0 in the address phase and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A transfer is requested |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the transfer |
| req_wdata | input | DW | Write data |
| req_hi | input | 1 | Upper byte lane is enabled |
| req_ready | output | 1 | Request can be taken this clock |
| ad_o | output | AW | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_i | input | DW | Value read back from the shared lines |
| ale | output | 1 | Address latch enable pulse |
| bhe_n | output | 1 | Upper byte lane enable, active low |
| dir_tx | output | 1 | Transceiver direction, 1 = toward the bus |
| den | output | 1 | Transceiver enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_ready | input | 1 | Device ready; low inserts wait states |
| rd_data | output | DW | Captured read data |
| done | output | 1 | One-clock completion pulse |

## Verification
A request driven before edge k places the address phase in the clock after edge k. The turnaround phase is one clock later and the data phase two clocks later. Each low ready sample taken at the end of the data phase or of a wait state pushes the final phase out by one clock, and `done` and the captured read data are visible in the final phase. All outputs are decoded from the registered state, so the bench drives inputs and samples outputs on falling edges and steps one falling edge per phase. The shared-line input carries a decoy value until ready rises and is changed again after capture, which pins down the exact edge at which read data is captured.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_hi,
  output logic          req_ready,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] bus_ad_i,
  output logic          ale,
  output logic          bhe_n,
  output logic          dir_tx,
  output logic          den,
  output logic          rd_n,
  output logic          wr_n,
  input  logic          bus_ready,
  output logic [DW-1:0] rd_data,
  output logic          done
);

  localparam int PAD = AW - DW;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ADR  = 3'd1,
    S_TURN = 3'd2,
    S_DAT  = 3'd3,
    S_WAIT = 3'd4,
    S_END  = 3'd5
  } phase_t;

  phase_t          ph, ph_nx;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            wr_q;
  logic            hi_q;
  logic [DW-1:0]   rdat_q;

  logic take, busy, strobe, xfer, sample;

  assign req_ready = (ph == S_IDLE) || (ph == S_END);
  assign take      = req_valid && req_ready;
  assign busy      = (ph != S_IDLE);
  assign strobe    = (ph == S_TURN) || (ph == S_DAT) || (ph == S_WAIT);
  assign xfer      = strobe || (ph == S_END);
  assign sample    = ((ph == S_DAT) || (ph == S_WAIT)) && bus_ready;

  always_comb begin
    ph_nx = ph;
    unique case (ph)
      S_IDLE:  if (take) ph_nx = S_ADR;
      S_ADR:   ph_nx = S_TURN;
      S_TURN:  ph_nx = S_DAT;
      S_DAT:   ph_nx = bus_ready ? S_END : S_WAIT;
      S_WAIT:  ph_nx = bus_ready ? S_END : S_WAIT;
      S_END:   ph_nx = take ? S_ADR : S_IDLE;
      default: ph_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      hi_q    <= 1'b0;
      rdat_q  <= '0;
    end else begin
      ph <= ph_nx;
      if (take) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
        hi_q    <= req_hi;
      end
      if (sample && !wr_q) rdat_q <= bus_ad_i;
    end
  end

  assign ale     = (ph == S_ADR);
  assign ad_o    = (ph == S_ADR) ? addr_q : {{PAD{1'b0}}, wdata_q};
  assign ad_oe   = (ph == S_ADR) || (xfer && wr_q);
  assign bhe_n   = busy ? !hi_q : 1'b1;
  assign dir_tx  = busy ? wr_q : 1'b1;
  assign den     = xfer;
  assign rd_n    = !(strobe && !wr_q);
  assign wr_n    = !(strobe && wr_q);
  assign rd_data = rdat_q;
  assign done    = (ph == S_END);

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ale,
  input logic ad_oe,
  input logic dir_tx,
  input logic den,
  input logic rd_n,
  input logic wr_n,
  input logic bus_ready,
  input logic done
);

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_ale_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $past(req_valid && req_ready));

  p_read_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (den && !dir_tx) |-> !ad_oe);

  p_strobes_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_rd_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !bus_ready) |=> !rd_n);

  p_wr_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !bus_ready) |=> !wr_n);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!rd_n || !wr_n));

  p_den_with_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> den);

  p_no_ale_and_den_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && den));

endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ale(ale), .ad_oe(ad_oe), .dir_tx(dir_tx), .den(den), .rd_n(rd_n),
  .wr_n(wr_n), .bus_ready(bus_ready), .done(done)
);

// File: tb/sim_mux_bus_seq.sv
`timescale 1ns/1ps
module sim_mux_bus_seq;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_hi = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] bus_ad_i = '0;
  logic bus_ready = 1'b1;
  logic req_ready, ad_oe, ale, bhe_n, dir_tx, den, rd_n, wr_n, done;
  logic [AW-1:0] ad_o;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_hi(req_hi),
    .req_ready(req_ready), .ad_o(ad_o), .ad_oe(ad_oe), .bus_ad_i(bus_ad_i),
    .ale(ale), .bhe_n(bhe_n), .dir_tx(dir_tx), .den(den), .rd_n(rd_n),
    .wr_n(wr_n), .bus_ready(bus_ready), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_check(input logic [DW-1:0] held);
    @(negedge clk);
    chk("R1 idle ale", ale, 0);
    chk("R1 idle ad_oe", ad_oe, 0);
    chk("R1 idle rd_n", rd_n, 1);
    chk("R1 idle wr_n", wr_n, 1);
    chk("R1 idle den", den, 0);
    chk("R1 idle done", done, 0);
    chk("R1 idle req_ready", req_ready, 1);
    chk("R1 idle dir_tx", dir_tx, 1);
    chk("R1 idle bhe_n", bhe_n, 1);
    chk("R7 rd_data held", rd_data, held);
  endtask

  // Enter at a falling edge while idle or in the final phase; leave at the
  // falling edge inside the final phase of the new cycle.
  task automatic run_cycle(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input bit hi, input int nw, input logic [DW-1:0] rv, input bit noise);
    logic [AW-1:0] wexp;
    wexp = {{(AW-DW){1'b0}}, wd};
    req_write = wr; req_addr = a; req_wdata = wd; req_hi = hi; req_valid = 1'b1;
    chk("R8 req_ready before take", req_ready, 1);
    @(negedge clk);
    chk("R2 ale", ale, 1);
    chk("R2 ad_oe", ad_oe, 1);
    chk("R2 ad_o addr", ad_o, a);
    chk("R2 bhe_n", bhe_n, !hi);
    chk("R2 dir_tx", dir_tx, wr);
    chk("R10 den off in address phase", den, 0);
    chk("R8 req_ready busy", req_ready, 0);
    if (noise) begin
      req_write = !wr; req_addr = 20'h0F0F0; req_wdata = 16'h1111; req_hi = !hi;
    end else req_valid = 1'b0;
    @(negedge clk);
    chk("R2 ale one clock", ale, 0);
    chk("R10 den turnaround", den, 1);
    if (wr) begin
      chk("R4 ad_oe turnaround", ad_oe, 1);
      chk("R4 ad_o data", ad_o, wexp);
      chk("R4 wr_n", wr_n, 0);
      chk("R4 rd_n", rd_n, 1);
    end else begin
      chk("R3 ad_oe turnaround", ad_oe, 0);
      chk("R3 rd_n", rd_n, 0);
      chk("R3 wr_n", wr_n, 1);
    end
    @(negedge clk);
    chk("R9 dir_tx kept", dir_tx, wr);
    chk("R9 bhe_n kept", bhe_n, !hi);
    chk(wr ? "R4 wr_n data" : "R3 rd_n data", wr ? wr_n : rd_n, 0);
    chk("R6 done early", done, 0);
    bus_ready = (nw == 0);
    bus_ad_i = (nw == 0) ? rv : 16'hDEAD;
    if (nw == 0) req_valid = 1'b0;
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      chk("R5 wait strobe", wr ? wr_n : rd_n, 0);
      chk("R5 wait no done", done, 0);
      chk("R10 den wait", den, 1);
      chk("R9 ad_oe kept", ad_oe, wr);
      if (i == nw - 1) begin
        bus_ready = 1'b1; bus_ad_i = rv; req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R6 done final", done, 1);
    chk("R3 R4 strobes off final", {rd_n, wr_n}, 2'b11);
    chk("R10 den final", den, 1);
    chk("R8 req_ready final", req_ready, 1);
    if (wr) begin
      chk("R4 ad_oe final", ad_oe, 1);
      chk("R4 R9 ad_o final", ad_o, wexp);
    end else begin
      chk("R3 ad_oe final", ad_oe, 0);
      chk("R7 rd_data", rd_data, rv);
    end
    bus_ad_i = 16'hBEEF;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", done, 0);
    chk("R1 reset ale", ale, 0);
    rst_n = 1'b1;
    idle_check(16'h0000);
    // read, no waits
    run_cycle(1'b0, 20'hA1234, 16'h0, 1'b1, 0, 16'h5A5A, 1'b0);
    idle_check(16'h5A5A);
    // write, no waits
    run_cycle(1'b1, 20'h00F02, 16'hC3C3, 1'b0, 0, 16'h0, 1'b0);
    idle_check(16'h5A5A);
    // read, three waits
    run_cycle(1'b0, 20'h12345, 16'h0, 1'b0, 3, 16'h7E81, 1'b0);
    idle_check(16'h7E81);
    // write, two waits, upper lane
    run_cycle(1'b1, 20'hFFFF1, 16'h9ABC, 1'b1, 2, 16'h0, 1'b0);
    idle_check(16'h7E81);
    // back to back: read then write then read
    run_cycle(1'b0, 20'h40000, 16'h0, 1'b1, 1, 16'h1357, 1'b0);
    run_cycle(1'b1, 20'h40002, 16'h2468, 1'b1, 0, 16'h0, 1'b0);
    run_cycle(1'b0, 20'h40004, 16'h0, 1'b0, 0, 16'hACE1, 1'b0);
    idle_check(16'hACE1);
    // requests held while busy
    run_cycle(1'b1, 20'h0ABCD, 16'h4321, 1'b0, 1, 16'h0, 1'b1);
    idle_check(16'hACE1);
    run_cycle(1'b0, 20'h0DCBA, 16'h0, 1'b1, 2, 16'h6789, 1'b1);
    idle_check(16'h6789);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule